// File: doc/BRIEF.md
# Shared Memory Request/Grant Handshake

This block guards a memory region shared with a second, auxiliary processor. Each chip select of the local bus can be marked as leading to that shared region. When the local bus begins an access through a marked chip select, the block pulls an active-low request line toward the other processor. It holds the local cycle in wait until that processor answers on an active-low grant line. Only then does it raise a drive enable for the address, data and control buffers that face the shared memory.

The grant input comes from another clock domain, so it first passes a two-flop synchronizer. Once the buffers have been enabled for one full clock, the stall is released and the local access proceeds. When the local bus ends the access, the drive enable falls first and the request is withdrawn one clock later. A fresh request waits until the synchronized grant has been seen released. Accesses through chip selects that are not marked never touch the handshake.

Top module: `aux_shmem_hs`

## Requirements
- R1: While reset is applied and in the cycle after it, `req_n` is 1 and `drv` is 0.
- R2: An access whose `cs_hit` bits do not overlap the set bits of `aux_en` never asserts `req_n`, `drv` or `stall`.
- R3: With the grant released and the handshake idle, `req_n` goes low on the first clock edge after `acc_vld` rises with a marked chip select hit.
- R4: `ack_n` is used only after two synchronizing flops: `drv` rises on the third clock edge after `ack_n` falls while a request is pending.
- R5: `drv` is 1 only while `req_n` is 0 and only after a synchronized grant.
- R6: `stall` stays 1 during a marked access until `drv` has been 1 for one full clock, and falls on the next edge after that.
- R7: When `acc_vld` falls during the drive phase, `drv` falls on the next edge while `req_n` stays 0, and `req_n` returns to 1 one edge later.
- R8: After a handshake ends, a new request is not issued while the synchronized grant is still low; with a marked access pending, `req_n` goes low on the third edge after `ack_n` rises.
- R9: `stall` is 1 combinationally in the cycle a marked access starts, and remains 1 during the whole wait for the grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Local access in progress, held until the access ends |
| cs_hit | input | NUM_CS | Chip selects decoded for the current access |
| aux_en | input | NUM_CS | Per chip select: 1 marks it as leading to shared memory |
| ack_n | input | 1 | Grant from the auxiliary processor, active low, asynchronous |
| req_n | output | 1 | Request to the auxiliary processor, active low |
| drv | output | 1 | Enable for the shared address, data and control buffers |
| stall | output | 1 | Holds the local cycle in wait |

## Verification
On every cycle the assertions check that the drive enable never appears without a request, that it rises only after a synchronized grant, that a request starts only from a released grant on a marked access, that the release order drive-then-request holds, and that the stall is never dropped before one driven clock. The exact latencies through the synchronizer, the gating of a new request on a still-held grant, and the silence of unmarked chip selects are shown only by the bench scenarios, which mix directed cases with random grant latencies, hold times and chip-select markings.

// File: rtl/aux_hs_pkg.sv
// Shared types of the shared-memory handshake.
// Assumes nothing beyond a single clock domain for the state register.
package aux_hs_pkg;

    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,  // no handshake in progress
        HS_REQ     = 3'd1,  // request out, waiting for the synchronized grant
        HS_GRANT   = 3'd2,  // first driven clock, local cycle still held
        HS_DRIVE   = 3'd3,  // buffers driven, local cycle running
        HS_RELEASE = 3'd4   // drive off, request still held for one clock
    } hs_state_t;

endpackage

// File: rtl/aux_hs_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a level that stays stable far longer than a clock.
// The reset value lets an active-low input start in its released state.
module aux_hs_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/aux_hs_csmatch.sv
// Decides whether the current local access targets shared memory.
// Assumes cs_hit and aux_en are valid whenever acc_vld is high.
module aux_hs_csmatch #(
    parameter int NUM_CS = 8
) (
    input  logic              acc_vld,
    input  logic [NUM_CS-1:0] cs_hit,
    input  logic [NUM_CS-1:0] aux_en,
    output logic              aux_acc
);

    logic [NUM_CS-1:0] marked_hit;

    // One gate per chip select: hit and marked for shared memory.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign marked_hit[g] = cs_hit[g] & aux_en[g];
    end

    assign aux_acc = acc_vld & (|marked_hit);

endmodule

// File: rtl/aux_hs_fsm.sv
// Request/grant state machine toward the auxiliary processor.
// Assumes ack_s_n is already synchronized and the local bus keeps acc_vld
// high while stall is asserted.
module aux_hs_fsm
    import aux_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic aux_acc,
    input  logic acc_vld,
    input  logic ack_s_n,
    output logic req_n,
    output logic drv,
    output logic stall
);

    hs_state_t state_q, state_d;

    // Next-state selection for the handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:    if (aux_acc && ack_s_n) state_d = HS_REQ;
            HS_REQ:     if (!ack_s_n)           state_d = HS_GRANT;
            HS_GRANT:   state_d = acc_vld ? HS_DRIVE : HS_RELEASE;
            HS_DRIVE:   if (!acc_vld)           state_d = HS_RELEASE;
            HS_RELEASE: state_d = HS_IDLE;
            default:    state_d = HS_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_d;
    end

    // Registered-state decode of the outward handshake lines.
    assign req_n = (state_q == HS_IDLE);
    assign drv   = (state_q == HS_GRANT) || (state_q == HS_DRIVE);
    // Hold the local cycle until the buffers have been driven one clock.
    assign stall = aux_acc && (state_q != HS_DRIVE);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (req_n && !drv));

    // R5
    drv_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> !req_n);

    // R4
    drv_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv) |-> !$past(ack_s_n));

    // R8
    req_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(ack_s_n));

    // R2
    req_only_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_n) |-> $past(aux_acc));

    // R7
    drv_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv) |-> !req_n ##1 req_n);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_acc && !stall) |-> (drv && $past(drv)));

endmodule

// File: rtl/aux_shmem_hs.sv
// Top of the shared-memory handshake: chip-select match, grant
// synchronizer and request/grant state machine.
// Assumes one clock; ack_n may change at any time.
module aux_shmem_hs #(
    parameter int NUM_CS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [NUM_CS-1:0] cs_hit,
    input  logic [NUM_CS-1:0] aux_en,
    input  logic              ack_n,
    output logic              req_n,
    output logic              drv,
    output logic              stall
);

    logic aux_acc;
    logic ack_s_n;

    // Flag accesses that target the shared region.
    aux_hs_csmatch #(.NUM_CS(NUM_CS)) i_match (
        .acc_vld (acc_vld),
        .cs_hit  (cs_hit),
        .aux_en  (aux_en),
        .aux_acc (aux_acc)
    );

    // Bring the grant into the local clock domain.
    aux_hs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ack_n),
        .sync_o  (ack_s_n)
    );

    // Sequence request, drive and stall.
    aux_hs_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .aux_acc (aux_acc),
        .acc_vld (acc_vld),
        .ack_s_n (ack_s_n),
        .req_n   (req_n),
        .drv     (drv),
        .stall   (stall)
    );

endmodule

// File: tb/test_aux_shmem_hs.sv
module test_aux_shmem_hs;
    localparam int  NUM_CS = 8;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_vld = 1'b0;
    logic [NUM_CS-1:0] cs_hit = '0;
    logic [NUM_CS-1:0] aux_en = '0;
    logic ack_n = 1'b1;
    logic req_n, drv, stall;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aux_shmem_hs #(.NUM_CS(NUM_CS), .SYNC_STAGES(2)) i_aux_shmem_hs (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .cs_hit(cs_hit),
        .aux_en(aux_en), .ack_n(ack_n), .req_n(req_n), .drv(drv), .stall(stall)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req, input logic e_req_n, input logic e_drv, input logic e_stall);
        chk(req_n === e_req_n, {req, " req_n"}, int'(req_n), int'(e_req_n));
        chk(drv === e_drv,     {req, " drv"},   int'(drv),   int'(e_drv));
        chk(stall === e_stall, {req, " stall"}, int'(stall), int'(e_stall));
    endtask

    // Pick a one-hot chip select that is marked (mark=1) or unmarked in cfg.
    function automatic logic [NUM_CS-1:0] pick_cs(input logic [NUM_CS-1:0] cfg, input bit mark, input int start);
        for (int k = 0; k < NUM_CS; k++) begin
            int idx = (start + k) % NUM_CS;
            if (cfg[idx] == mark) return NUM_CS'(1) << idx;
        end
        return '0;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    // Unmarked access: handshake stays silent (R2).
    task automatic plain_access(input logic [NUM_CS-1:0] cs, input int hold);
        acc_vld = 1'b1; cs_hit = cs; #1;
        chk_out("R2", 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < hold; i++) begin
            step(); chk_out("R2", 1'b1, 1'b0, 1'b0);
        end
        acc_vld = 1'b0; cs_hit = '0;
        step(); chk_out("R2", 1'b1, 1'b0, 1'b0);
    endtask

    // Marked access with grant latency lat, driven hold cycles hold,
    // rel cycles of still-held grant at start, keep grant low at end if keep.
    task automatic aux_access(input logic [NUM_CS-1:0] cs, input int lat, input int hold,
                              input int rel, input bit keep);
        acc_vld = 1'b1; cs_hit = cs; #1;
        chk(stall === 1'b1, "R9 stall on start", int'(stall), 1);
        if (ack_n === 1'b0) begin
            for (int i = 0; i < rel; i++) begin
                step(); chk_out("R8 held grant", 1'b1, 1'b0, 1'b1);
            end
            ack_n = 1'b1;
            step(); chk_out("R8 sync 1", 1'b1, 1'b0, 1'b1);
            step(); chk_out("R8 sync 2", 1'b1, 1'b0, 1'b1);
            step(); chk_out("R8 request", 1'b0, 1'b0, 1'b1);
        end else begin
            step(); chk_out("R3 request", 1'b0, 1'b0, 1'b1);
        end
        for (int i = 0; i < lat; i++) begin
            step(); chk_out("R9 wait grant", 1'b0, 1'b0, 1'b1);
        end
        ack_n = 1'b0;
        step(); chk_out("R4 sync 1", 1'b0, 1'b0, 1'b1);
        step(); chk_out("R4 sync 2", 1'b0, 1'b0, 1'b1);
        step(); chk_out("R4 R5 drive", 1'b0, 1'b1, 1'b1);
        step(); chk_out("R6 release stall", 1'b0, 1'b1, 1'b0);
        for (int i = 1; i < hold; i++) begin
            step(); chk_out("R6 driven", 1'b0, 1'b1, 1'b0);
        end
        acc_vld = 1'b0; cs_hit = '0;
        step(); chk_out("R7 drive off", 1'b0, 1'b0, 1'b0);
        step(); chk_out("R7 request off", 1'b1, 1'b0, 1'b0);
        if (!keep) begin
            ack_n = 1'b1;
            step(); step(); step();
            chk_out("R8 idle", 1'b1, 1'b0, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) step();
        // R1: outputs inactive during and just after reset
        chk_out("R1 in reset", 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        chk_out("R1 after reset", 1'b1, 1'b0, 1'b0);

        aux_en = 8'b0000_0101;
        plain_access(8'b0000_0010, 3);                 // R2 unmarked
        aux_access(8'b0000_0001, 0, 1, 0, 1'b0);       // R3 R4 fastest grant
        aux_access(8'b0000_0100, 5, 4, 0, 1'b1);       // keep grant held
        aux_access(8'b0000_0001, 2, 2, 4, 1'b0);       // R8 wait for release
        aux_access(8'b0000_0001, 0, 1, 0, 1'b1);
        aux_access(8'b0000_0100, 1, 1, 0, 1'b0);       // R8 rel=0 edge
        aux_en = '0;
        plain_access(8'b1111_1111, 2);                 // R2 nothing marked
        aux_en = 8'b1000_0000;
        plain_access(8'b0111_1111, 1);                 // R2 other bits

        for (int it = 0; it < 60; it++) begin
            logic [NUM_CS-1:0] cfg;
            bit mark;
            cfg = NUM_CS'($urandom);
            aux_en = cfg;
            mark = ($urandom % 3) != 0;
            if (ack_n === 1'b0) mark = 1'b1;
            if (mark && cfg == '0) begin cfg[$urandom % NUM_CS] = 1'b1; aux_en = cfg; end
            if (!mark && cfg == '1) mark = 1'b1;
            if (mark)
                aux_access(pick_cs(cfg, 1'b1, int'($urandom % NUM_CS)),
                           int'($urandom % 6), 1 + int'($urandom % 5),
                           int'($urandom % 4), bit'($urandom % 2));
            else
                plain_access(pick_cs(cfg, 1'b0, int'($urandom % NUM_CS)), int'($urandom % 4));
        end
        if (ack_n === 1'b0) begin
            ack_n = 1'b1; step(); step(); step();
        end
        chk_out("R1 final idle", 1'b1, 1'b0, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule